// File: doc/BRIEF.md
# Multi-master I2C clock synchronizer

This block produces one master's drive for a shared, open-drain I2C clock line. The line is a wired-AND: whichever device pulls it low holds it low. The block therefore never assumes that releasing its own pull makes the line rise. It samples the line through a two-stage synchronizer and starts each phase from the level it actually observes. As a result, every participant ends up with the same clock. The low phase lasts as long as the slowest device wants, and the high phase is as short as the most impatient device allows.

Software-visible registers elsewhere supply two period counts, in system-clock cycles, for the low and the high phase. An enable starts and stops clock generation. The outputs are a pull-down request for the line's open-drain driver and two single-cycle strobes. The bit-level shifter uses these strobes to time its data changes and its samples. Each period count is latched when its phase begins, so a register write made mid-phase takes effect from the next phase.

Top module: `scl_sync_top`

## Requirements
- R1: After reset, and while enable is low, the pull-down output is 0 and both strobes stay 0.
- R2: Each own low phase holds the pull-down output at 1 for exactly max(low period, 2) consecutive cycles. The low strobe is high in the first of those cycles and only then.
- R3: After the pull-down is released, the high strobe fires three cycles after the first cycle in which the line reads high (two synchronizer stages plus one decision cycle). With no other device on the line, the cycle count from low strobe to high strobe is max(low period, 2) + 3.
- R4: If another device keeps the line low for S cycles counted from the low strobe, the low strobe to high strobe distance is max(S, max(low period, 2)) + 3. A shorter external hold has no effect.
- R5: With no interference, the cycle count from high strobe to the next low strobe is max(high period, 2), after which the block pulls the line low itself.
- R6: If another device pulls the line low X cycles after it rose, with X below the own high count, the high phase is abandoned. The next low strobe follows X cycles after the high strobe, and a full own low phase is then counted.
- R7: If the own high count expires in the same cycle that the synchronized line is first seen low, exactly one low strobe is produced. The following low phase still measures max(low period, 2) + 3 cycles to the high strobe.
- R8: Period values 0 and 1 behave as 2. No pull-down run while enabled is shorter than 2 cycles.
- R9: Clearing enable releases the pull-down on the next cycle and silences both strobes. Setting enable again while the line reads high gives a high strobe on the next cycle.
- R10: The low and high strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock generation enable |
| scl_in | input | 1 | Raw level read back from the shared clock line |
| low_period | input | 16 | Low phase length in system cycles (minimum 2) |
| high_period | input | 16 | High phase length in system cycles (minimum 2) |
| scl_drive_low | output | 1 | 1 requests the open-drain driver to pull the line low |
| low_start | output | 1 | One-cycle strobe in the first cycle of a low phase |
| high_start | output | 1 | One-cycle strobe in the first cycle of a high phase |

## Verification
The two functions that can coincide are the expiry of the block's own high count and the detection of another master pulling the line low. Both ask for a new low phase in the same cycle. The bench provokes this with a modelled second master that cuts the high phase after exactly the same number of cycles as the block's own high count. It then judges the result through the scoreboard: the cycle counts between successive strobes must still match the expected periods, so a doubled or missed low strobe shows up as a wrong interval.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

    localparam int unsigned MIN_PERIOD = 2;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned N_TIMERS   = 2;
    localparam int unsigned IDX_LOW    = 0;
    localparam int unsigned IDX_HIGH   = 1;

    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_LOW     = 2'd1,
        PH_RELEASE = 2'd2,
        PH_HIGH    = 2'd3
    } phase_t;

    typedef struct packed {
        logic drive_low;
        logic low_start;
        logic high_start;
    } line_out_t;

    typedef struct packed {
        phase_t nxt;
        logic   load_low;
        logic   load_high;
    } phase_step_t;

    function automatic logic [31:0] clamp_period(input logic [31:0] raw);
        return (raw < MIN_PERIOD) ? 32'(MIN_PERIOD) : raw;
    endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int unsigned STAGES = scl_sync_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    output logic line_hi
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) shreg <= '1;
                else     shreg <= line_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) shreg <= '1;
                else     shreg <= {shreg[STAGES-2:0], line_raw};
            end
        end
    endgenerate

    assign line_hi = shreg[STAGES-1];
endmodule

// File: rtl/scl_period_counter.sv
module scl_period_counter
    import scl_sync_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] remain;
    logic [W-1:0] limit_eff;

    assign limit_eff = W'(clamp_period(32'(limit)));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            remain <= '0;
        end else if (load) begin
            remain <= limit_eff;
        end else if (run && remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign done = run && (remain == ONE);
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      line_hi,
    input  logic      low_done,
    input  logic      high_done,
    output logic      load_low,
    output logic      load_high,
    output logic      run_low,
    output logic      run_high,
    output phase_t    phase,
    output line_out_t line_out
);
    phase_step_t step;

    always_comb begin
        step.nxt       = phase;
        step.load_low  = 1'b0;
        step.load_high = 1'b0;
        if (!en) begin
            step.nxt = PH_OFF;
        end else begin
            unique case (phase)
                PH_OFF: begin
                    if (line_hi) begin
                        step.nxt       = PH_HIGH;
                        step.load_high = 1'b1;
                    end else begin
                        step.nxt      = PH_LOW;
                        step.load_low = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (low_done) step.nxt = PH_RELEASE;
                end
                PH_RELEASE: begin
                    if (line_hi) begin
                        step.nxt       = PH_HIGH;
                        step.load_high = 1'b1;
                    end
                end
                PH_HIGH: begin
                    // observed low and own expiry both lead to one low entry
                    if (!line_hi || high_done) begin
                        step.nxt      = PH_LOW;
                        step.load_low = 1'b1;
                    end
                end
                default: step.nxt = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OFF;
            line_out <= '0;
        end else begin
            phase               <= step.nxt;
            line_out.drive_low  <= (step.nxt == PH_LOW);
            line_out.low_start  <= (step.nxt == PH_LOW)  && (phase != PH_LOW);
            line_out.high_start <= (step.nxt == PH_HIGH) && (phase != PH_HIGH);
        end
    end

    assign load_low  = step.load_low;
    assign load_high = step.load_high;
    assign run_low   = (phase == PH_LOW);
    assign run_high  = (phase == PH_HIGH);
endmodule

// File: rtl/scl_sync_top.sv
module scl_sync_top
    import scl_sync_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         scl_in,
    input  logic [W-1:0] low_period,
    input  logic [W-1:0] high_period,
    output logic         scl_drive_low,
    output logic         low_start,
    output logic         high_start
);
    logic                line_hi;
    logic [N_TIMERS-1:0] load_v;
    logic [N_TIMERS-1:0] run_v;
    logic [N_TIMERS-1:0] done_v;
    logic [W-1:0]        limit_v [N_TIMERS];
    phase_t              phase;
    line_out_t           line_out;

    scl_line_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_raw (scl_in),
        .line_hi  (line_hi)
    );

    assign limit_v[IDX_LOW]  = low_period;
    assign limit_v[IDX_HIGH] = high_period;

    generate
        for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
            scl_period_counter #(.W(W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .clear (!en),
                .load  (load_v[i]),
                .run   (run_v[i]),
                .limit (limit_v[i]),
                .done  (done_v[i])
            );
        end
    endgenerate

    scl_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .line_hi   (line_hi),
        .low_done  (done_v[IDX_LOW]),
        .high_done (done_v[IDX_HIGH]),
        .load_low  (load_v[IDX_LOW]),
        .load_high (load_v[IDX_HIGH]),
        .run_low   (run_v[IDX_LOW]),
        .run_high  (run_v[IDX_HIGH]),
        .phase     (phase),
        .line_out  (line_out)
    );

    assign scl_drive_low = line_out.drive_low;
    assign low_start     = line_out.low_start;
    assign high_start    = line_out.high_start;
endmodule

// File: rtl/scl_sync_checker.sv
module scl_sync_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic line_hi,
    input logic scl_drive_low,
    input logic low_start,
    input logic high_start
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)                run_len <= '0;
        else if (scl_drive_low) run_len <= run_len + 32'd1;
        else                    run_len <= '0;
    end

    // R10: strobes never coincide
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(low_start && high_start));

    // R2: low strobe marks the first pull-down cycle
    p_low_edge_r2: assert property (@(posedge clk) disable iff (rst)
        low_start |-> (scl_drive_low && !$past(scl_drive_low)));

    // R3: a high phase only opens after the synchronized line read high
    p_high_seen_r3: assert property (@(posedge clk) disable iff (rst)
        high_start |-> $past(line_hi));

    // R9: disable releases the line and silences strobes
    p_disable_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_drive_low && !low_start && !high_start));

    // R8: an enabled pull-down run is at least two cycles
    p_min_low_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_drive_low) && $past(en)) |-> (run_len >= 32'd2));
endmodule

bind scl_sync_top scl_sync_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .line_hi       (line_hi),
    .scl_drive_low (scl_drive_low),
    .low_start     (low_start),
    .high_start    (high_start)
);

// File: tb/tb_scl_sync_top.sv
module tb_scl_sync_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] low_period  = 16'd5;
    logic [15:0] high_period = 16'd5;
    logic        scl_drive_low, low_start, high_start;
    logic        other_pull = 1'b0;
    logic        bus;

    assign bus = !(scl_drive_low || other_pull);

    always #2.5 clk = ~clk;

    scl_sync_top dut (
        .clk(clk), .rst(rst), .en(en), .scl_in(bus),
        .low_period(low_period), .high_period(high_period),
        .scl_drive_low(scl_drive_low), .low_start(low_start), .high_start(high_start)
    );

    typedef struct {
        int    cycles;
        string tag;
    } exp_t;

    exp_t low_q[$];
    exp_t high_q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 0;

    // second device on the line: 0 idle, 1 stretches low, 2 cuts high
    int mode = 0;
    int mode_p = 0;
    localparam int CUT_HOLD = 3;

    initial begin : other_device
        logic prev;
        int   ocnt, hcnt;
        bit   harm;
        prev = 1'b1; ocnt = 0; hcnt = 0; harm = 0;
        forever begin
            @(posedge clk);
            if (other_pull) begin
                if (ocnt == 1) other_pull <= 1'b0;
                ocnt = ocnt - 1;
            end else if (mode == 1 && bus == 1'b0 && prev == 1'b1 && mode_p > 1) begin
                other_pull <= 1'b1;
                ocnt = mode_p - 1;
            end
            if (mode == 2) begin
                if (harm) begin
                    if (hcnt == 1) begin
                        other_pull <= 1'b1;
                        ocnt = CUT_HOLD;
                        harm = 0;
                    end else hcnt = hcnt - 1;
                end else if (bus == 1'b1 && prev == 1'b0) begin
                    harm = 1;
                    hcnt = mode_p - 1;
                end
            end else harm = 0;
            prev = bus;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: measures strobe-to-strobe distances, compares with queue
    initial begin : monitor
        int cyc, t_low, t_high;
        bit seen_low, seen_high;
        exp_t e;
        cyc = 0; t_low = 0; t_high = 0; seen_low = 0; seen_high = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (low_start) begin
                if (seen_high && high_q.size() > 0) begin
                    e = high_q.pop_front();
                    check((cyc - t_high) == e.cycles, e.tag, cyc - t_high, e.cycles);
                end
                t_low = cyc; seen_low = 1;
            end
            if (high_start) begin
                if (seen_low && low_q.size() > 0) begin
                    e = low_q.pop_front();
                    check((cyc - t_low) == e.cycles, e.tag, cyc - t_low, e.cycles);
                end
                t_high = cyc; seen_high = 1;
            end
        end
    end

    task automatic wait_highs(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!high_start) @(negedge clk);
        end
    endtask

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic run_case(input int l, input int h, input int m, input int p,
                            input string tl, input string th);
        int el, eh;
        @(negedge clk);
        low_period  = 16'(l);
        high_period = 16'(h);
        mode   = m;
        mode_p = p;
        el = eff(l) + 3;
        if (m == 1 && p > eff(l)) el = p + 3;
        eh = eff(h);
        if (m == 2 && p < eff(h)) eh = p;
        wait_highs(3);
        for (int i = 0; i < 4; i++) begin
            low_q.push_back('{el, tl});
            high_q.push_back('{eh, th});
        end
        while (low_q.size() > 0 || high_q.size() > 0) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        check(!scl_drive_low && !low_start && !high_start, "R1 in reset", scl_drive_low, 0);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!scl_drive_low && !low_start && !high_start, "R1 idle", scl_drive_low, 0);
        end
        en = 1'b1;
        @(negedge clk);
        check(high_start == 1'b1, "R9 start high", high_start, 1);

        run_case(5, 7, 0, 0, "R3 low 5", "R5 high 7");
        run_case(10, 4, 0, 0, "R2 low 10", "R5 high 4");
        run_case(5, 6, 1, 20, "R4 stretch 20", "R5 high 6 stretch");
        run_case(6, 5, 1, 3, "R4 short hold", "R5 high 5 short hold");
        run_case(6, 10, 2, 4, "R6 low after cut", "R6 cut at 4");
        run_case(5, 8, 2, 8, "R7 low collision", "R7 high collision");
        run_case(1, 0, 0, 0, "R8 low 1", "R8 high 0");
        run_case(0, 1, 0, 0, "R8 low 0", "R8 high 1");
        run_case(300, 200, 0, 0, "R3 low 300", "R5 high 200");

        // R2: direct pull-down run length
        run_case(7, 5, 0, 0, "R3 low 7", "R5 high 5");
        @(negedge clk);
        while (!low_start) @(negedge clk);
        begin
            int n;
            n = 0;
            while (scl_drive_low) begin n++; @(negedge clk); end
            check(n == 7, "R2 pull run", n, 7);
        end

        // R9: disable mid low phase
        @(negedge clk);
        while (!low_start) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R9 release", scl_drive_low, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!scl_drive_low && !low_start && !high_start, "R9 quiet", low_start | high_start, 0);
        end
        en = 1'b1;
        @(negedge clk);
        check(high_start == 1'b1, "R9 restart", high_start, 1);
        run_case(4, 4, 0, 0, "R3 low 4 after restart", "R5 high 4 after restart");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule